// File: doc/BRIEF.md
# Reference Clock Pre-Divider to 8 kHz

This block turns one chosen reference clock into a stream of phase-comparison events for a downstream phase detector. All reference inputs are sampled in a fast system clock. Each input passes through its own two-flop synchronizer and edge detector. A selector picks one input. A divider then counts that input's detected edges and emits a one-cycle compare pulse at terminal count.

Each input has a configuration word that decides how its edges are handled. The word holds a spot-frequency code, a lock-to-8-kHz bit and a divide-by-N bit. There are three ways to handle the edges:
- Pass-through: every edge is forwarded as a compare event.
- Spot-frequency division: the input is divided down to 8 kHz by a ratio that follows from its nominal frequency.
- Shared divider: the input is divided by N+1, where N is one shared programmable value.

A network-type bit decides whether the low-rate telecom code stands for 1.544 MHz or 2.048 MHz. A global flag tells the neighbouring monitor logic to stop frequency checks whenever any input uses the shared divider.

Top module: `refdiv_top`

## Requirements
- R1: After reset `cmp_pulse` is 0 and the divider count is zero. The network-type bit takes the value of `net_strap`.
- R2: With both division bits clear, every selected edge of the chosen input gives exactly one `cmp_pulse`, one cycle wide. For a rising edge, the pulse is high in the third clock cycle after the input changes (two synchronizer stages plus the output register).
- R3: With the lock bit (cfg bit 6) set and a spot code of 0 (2 kHz), 1 (4 kHz) or 2 (8 kHz), the input is passed through undivided.
- R4: With the lock bit set and the divide bit (cfg bit 7) clear, the divide ratio follows from the spot code in cfg bits 5:0. Each ratio is the nominal frequency divided by 8 kHz:
  - code 3: see R5
  - code 4 (6.48 MHz): 810
  - code 5 (19.44 MHz): 2430
  - code 6 (25.92 MHz): 3240
  - code 7 (38.88 MHz): 4860
  - code 8 (51.84 MHz): 6480
  - code 9 (77.76 MHz): 9720
- R5: Spot code 3 divides by 193 (1.544 MHz) when the network-type bit is 1 and by 256 (2.048 MHz) when it is 0. A pulse on `net_wr` loads `net_wr_val` into the network-type bit.
- R6: With both the lock bit and the divide bit set, the input is divided by `divn_value`+1. The same value applies to every input that uses the shared divider.
- R7: The divide bit without the lock bit has no effect, and the input is passed through.
- R8: `freq_mon_off` is 1 whenever the divide bit of any input is set, selected or not, and 0 otherwise.
- R9: When `edge_fall` is 1, only falling edges of the input count. When it is 0, only rising edges count.
- R10: Any change to the selection, the selected configuration word, `divn_value`, `edge_fall` or the network-type bit restarts the count from zero. No pulse comes out in the cycle that follows such a change.
- R11: Edges on inputs that are not selected produce no compare pulse.
- R12: With the lock bit set, spot codes 10 to 63 are not defined and are passed through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | NUM_REFS | Raw reference clock inputs |
| ref_sel | input | SEL_W | Index of the input to condition |
| ref_cfg | input | NUM_REFS*CFG_W | Configuration words, input i at bits i*CFG_W and up |
| divn_value | input | DIVN_W | Shared divider value N (ratio N+1) |
| edge_fall | input | 1 | 1: count falling edges, 0: rising edges |
| net_strap | input | 1 | Network-type value loaded during reset |
| net_wr | input | 1 | Load strobe for the network-type bit |
| net_wr_val | input | 1 | Network-type value to load (1 = 1.544 MHz meaning) |
| cmp_pulse | output | 1 | One-cycle phase-comparison event |
| freq_mon_off | output | 1 | Frequency monitoring must be disabled |

## Verification
Pass-through is driven with single isolated edges, so the exact pulse cycle and width can be checked. Bursts of a chosen length are run against each division mode. Burst lengths land just over, or just short of, a multiple of the ratio, which separates ratios that differ by one. The 1.544/2.048 MHz code is run with the same burst under both network types, so a swapped mapping shows up as a wrong count. Partial counts interrupted by a selection change, toggling on unselected inputs, falling-edge mode and seeded random mixes of code, shared N, polarity and network type cover the rest.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int unsigned RATIO_W  = 14;
  localparam int unsigned CODE_W   = 6;
  localparam int unsigned LOCK_BIT = 6;
  localparam int unsigned DIVN_BIT = 7;

  typedef enum logic [CODE_W-1:0] {
    SPOT_2K    = 6'd0,
    SPOT_4K    = 6'd1,
    SPOT_8K    = 6'd2,
    SPOT_TELCO = 6'd3,
    SPOT_6M48  = 6'd4,
    SPOT_19M44 = 6'd5,
    SPOT_25M92 = 6'd6,
    SPOT_38M88 = 6'd7,
    SPOT_51M84 = 6'd8,
    SPOT_77M76 = 6'd9
  } spot_e;

  // Ratio that brings a spot frequency down to 8 kHz; 1 means pass-through.
  function automatic logic [RATIO_W-1:0] spot_ratio(input logic [CODE_W-1:0] code,
                                                   input logic sonet);
    logic [RATIO_W-1:0] r;
    case (code)
      SPOT_TELCO: r = sonet ? 14'd193 : 14'd256;
      SPOT_6M48:  r = 14'd810;
      SPOT_19M44: r = 14'd2430;
      SPOT_25M92: r = 14'd3240;
      SPOT_38M88: r = 14'd4860;
      SPOT_51M84: r = 14'd6480;
      SPOT_77M76: r = 14'd9720;
      default:    r = 14'd1;
    endcase
    return r;
  endfunction

  // Shared divider ratio N+1.
  function automatic logic [RATIO_W-1:0] shared_ratio(input logic [RATIO_W-1:0] n);
    return n + 14'd1;
  endfunction
endpackage

// File: rtl/refdiv_edge_det.sv
module refdiv_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic fall_sel,
  output logic lvl,
  output logic edge_evt
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], raw};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl      = chain[STAGES-1];
  assign edge_evt = fall_sel ? (prev & ~lvl) : (lvl & ~prev);
endmodule

// File: rtl/refdiv_ratio_sel.sv
module refdiv_ratio_sel
  import refdiv_pkg::*;
#(
  parameter int unsigned CFG_W = 8
) (
  input  logic [CFG_W-1:0]   cfg,
  input  logic [RATIO_W-1:0] divn_n,
  input  logic               sonet,
  output logic [RATIO_W-1:0] ratio,
  output logic               passthru
);
  logic              lock8k;
  logic              use_divn;
  logic [CODE_W-1:0] code;

  assign lock8k   = cfg[LOCK_BIT];
  assign use_divn = cfg[DIVN_BIT];
  assign code     = cfg[CODE_W-1:0];

  always_comb begin
    if (lock8k && use_divn)
      ratio = shared_ratio(divn_n);
    else if (lock8k)
      ratio = spot_ratio(code, sonet);
    else
      ratio = 14'd1;
  end

  assign passthru = (ratio == 14'd1);
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter
  import refdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               edge_evt,
  input  logic [RATIO_W-1:0] ratio,
  output logic [RATIO_W-1:0] cnt,
  output logic               pulse
);
  logic [RATIO_W:0] cnt_next;
  logic             terminal;

  assign cnt_next = {1'b0, cnt} + 1'b1;
  assign terminal = (cnt_next >= {1'b0, ratio});

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (edge_evt) begin
      if (terminal) begin
        cnt   <= '0;
        pulse <= 1'b1;
      end else begin
        cnt   <= cnt_next[RATIO_W-1:0];
        pulse <= 1'b0;
      end
    end else begin
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
#(
  parameter int unsigned NUM_REFS    = 4,
  parameter int unsigned CFG_W       = 8,
  parameter int unsigned DIVN_W      = 14,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SEL_W      = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REFS-1:0]       ref_in,
  input  logic [SEL_W-1:0]          ref_sel,
  input  logic [NUM_REFS*CFG_W-1:0] ref_cfg,
  input  logic [DIVN_W-1:0]         divn_value,
  input  logic                      edge_fall,
  input  logic                      net_strap,
  input  logic                      net_wr,
  input  logic                      net_wr_val,
  output logic                      cmp_pulse,
  output logic                      freq_mon_off
);
  localparam int unsigned SIG_W = SEL_W + CFG_W + DIVN_W + 2;

  logic [NUM_REFS-1:0] lvl_vec;
  logic [NUM_REFS-1:0] edge_vec;
  logic [NUM_REFS-1:0] divn_bits;
  logic [CFG_W-1:0]    cfg_arr [NUM_REFS];

  // Per-input synchronizer and edge detector
  for (genvar gi = 0; gi < NUM_REFS; gi++) begin : g_in
    assign cfg_arr[gi]   = ref_cfg[gi*CFG_W +: CFG_W];
    assign divn_bits[gi] = ref_cfg[gi*CFG_W + DIVN_BIT];
    refdiv_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw      (ref_in[gi]),
      .fall_sel (edge_fall),
      .lvl      (lvl_vec[gi]),
      .edge_evt (edge_vec[gi])
    );
  end

  // Network-type bit: strap during reset, strobe afterwards
  logic net_sonet;
  always_ff @(posedge clk) begin
    if (!rst_n)      net_sonet <= net_strap;
    else if (net_wr) net_sonet <= net_wr_val;
  end

  // Selection of one input, exposed as named wires
  logic [CFG_W-1:0]   cfg_sel;
  logic               edge_sel;
  logic               sel_lvl;
  logic               sel_divn;
  logic [RATIO_W-1:0] ratio;
  logic               passthru;

  assign cfg_sel  = cfg_arr[ref_sel];
  assign edge_sel = edge_vec[ref_sel];
  assign sel_lvl  = lvl_vec[ref_sel];
  assign sel_divn = cfg_sel[DIVN_BIT];

  refdiv_ratio_sel #(.CFG_W(CFG_W)) u_ratio (
    .cfg      (cfg_sel),
    .divn_n   (RATIO_W'(divn_value)),
    .sonet    (net_sonet),
    .ratio    (ratio),
    .passthru (passthru)
  );

  // Restart the count whenever anything that shapes it changes
  logic [SIG_W-1:0] sig_now;
  logic [SIG_W-1:0] sig_q;
  logic             clear_cnt;

  assign sig_now = {ref_sel, cfg_sel, divn_value, edge_fall, net_sonet};

  always_ff @(posedge clk) begin
    if (!rst_n) sig_q <= '0;
    else        sig_q <= sig_now;
  end

  assign clear_cnt = (sig_now != sig_q);

  logic [RATIO_W-1:0] cnt;

  refdiv_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear_cnt),
    .edge_evt (edge_sel),
    .ratio    (ratio),
    .cnt      (cnt),
    .pulse    (cmp_pulse)
  );

  assign freq_mon_off = |divn_bits;
endmodule

// File: rtl/refdiv_checks.sv
module refdiv_checks
  import refdiv_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               cmp_pulse,
  input logic               edge_sel,
  input logic               sel_lvl,
  input logic               edge_fall,
  input logic               clear_cnt,
  input logic [RATIO_W-1:0] ratio,
  input logic [RATIO_W-1:0] cnt,
  input logic               sel_divn,
  input logic               freq_mon_off,
  input logic               passthru
);
  AST_PULSE_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |-> ($past(edge_sel) && !$past(clear_cnt))); // R2

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |=> !cmp_pulse); // R2

  AST_PASSTHRU_EVERY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel && !clear_cnt && passthru) |=> cmp_pulse); // R3

  AST_CNT_BELOW_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_cnt && ratio != '0) |-> (cnt < ratio)); // R4

  AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    clear_cnt |=> (cnt == '0 && !cmp_pulse)); // R10

  AST_RISE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel && !edge_fall) |-> sel_lvl); // R9

  AST_FALL_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel && edge_fall) |-> !sel_lvl); // R9

  AST_FMO_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    sel_divn |-> freq_mon_off); // R8
endmodule

bind refdiv_top refdiv_checks chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmp_pulse    (cmp_pulse),
  .edge_sel     (edge_sel),
  .sel_lvl      (sel_lvl),
  .edge_fall    (edge_fall),
  .clear_cnt    (clear_cnt),
  .ratio        (ratio),
  .cnt          (cnt),
  .sel_divn     (sel_divn),
  .freq_mon_off (freq_mon_off),
  .passthru     (passthru)
);

// File: tb/refdiv_top_tb_top.sv
module refdiv_top_tb_top;
  localparam int NR = 4;
  localparam int CW = 8;
  localparam int DW = 14;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NR-1:0]   ref_in;
  logic [1:0]      ref_sel;
  logic [NR*CW-1:0] ref_cfg;
  logic [DW-1:0]   divn_value;
  logic            edge_fall, net_strap, net_wr, net_wr_val;
  logic            cmp_pulse, freq_mon_off;

  always #4 clk = ~clk;

  refdiv_top dut_i (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .ref_sel(ref_sel), .ref_cfg(ref_cfg),
    .divn_value(divn_value), .edge_fall(edge_fall), .net_strap(net_strap),
    .net_wr(net_wr), .net_wr_val(net_wr_val), .cmp_pulse(cmp_pulse),
    .freq_mon_off(freq_mon_off)
  );

  int tests = 0;
  int fails = 0;
  int pulse_cnt = 0;
  int width_err = 0;
  bit pulse_prev = 1'b0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (cmp_pulse) pulse_cnt++;
    if (cmp_pulse && pulse_prev) width_err++;
    pulse_prev = cmp_pulse;
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int spot_khz(int code, bit sonet);
    case (code)
      0: return 2;
      1: return 4;
      2: return 8;
      3: return sonet ? 1544 : 2048;
      4: return 6480;
      5: return 19440;
      6: return 25920;
      7: return 38880;
      8: return 51840;
      9: return 77760;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_ratio(bit [7:0] w, int n, bit sonet);
    int k;
    if (!w[6]) return 1;
    if (w[7]) return n + 1;
    k = spot_khz(int'(w[5:0]), sonet);
    if (k <= 8) return 1;
    return k / 8;
  endfunction

  task automatic settle();
    repeat (4) @(negedge clk);
    pulse_cnt = 0;
  endtask

  task automatic setup(int idx, bit [7:0] w, int n, bit fall);
    @(negedge clk);
    ref_sel = 2'(idx);
    ref_cfg[idx*CW +: CW] = w;
    divn_value = DW'(n);
    edge_fall = fall;
    settle();
  endtask

  task automatic set_net(bit v);
    @(negedge clk);
    net_wr = 1'b1; net_wr_val = v;
    @(negedge clk);
    net_wr = 1'b0;
    settle();
  endtask

  task automatic toggles(int idx, int n);
    for (int i = 0; i < n; i++) begin
      ref_in[idx] = 1'b1;
      repeat (2) @(negedge clk);
      ref_in[idx] = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic run_case(string req, int idx, int n, int ratio);
    pulse_cnt = 0;
    toggles(idx, n);
    repeat (6) @(negedge clk);
    check(req, pulse_cnt, n / ratio);
    pulse_cnt = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    bit sonet_m;
    rst_n = 1'b0; ref_in = '0; ref_sel = '0; ref_cfg = '0; divn_value = '0;
    edge_fall = 1'b0; net_strap = 1'b1; net_wr = 1'b0; net_wr_val = 1'b0;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 pulse", int'(cmp_pulse), 0);
    check("R1 fmo", int'(freq_mon_off), 0);

    // R2: exact latency of a pass-through rising edge
    setup(0, 8'h00, 0, 1'b0);
    ref_in[0] = 1'b1;
    @(negedge clk); check("R2 lat1", int'(cmp_pulse), 0);
    @(negedge clk); check("R2 lat2", int'(cmp_pulse), 0);
    @(negedge clk); check("R2 lat3", int'(cmp_pulse), 1);
    @(negedge clk); check("R2 lat4", int'(cmp_pulse), 0);
    ref_in[0] = 1'b0;
    settle();
    run_case("R2", 0, 7, 1);

    // R3 / R12: low spot codes and undefined codes pass through
    setup(0, 8'h42, 0, 1'b0); run_case("R3 8k", 0, 5, exp_ratio(8'h42, 0, 1));
    setup(0, 8'h40, 0, 1'b0); run_case("R3 2k", 0, 4, 1);
    setup(0, 8'h4D, 0, 1'b0); run_case("R12", 0, 6, exp_ratio(8'h4D, 0, 1));

    // R1 / R5: strap gave SONET mapping; then SDH by strobe
    setup(0, 8'h43, 0, 1'b0); run_case("R5 sonet", 0, 386, exp_ratio(8'h43, 0, 1));
    set_net(1'b0);            run_case("R5 sdh", 0, 386, exp_ratio(8'h43, 0, 0));
    sonet_m = 1'b0;

    // R4: table ratios
    setup(0, 8'h44, 0, 1'b0); run_case("R4 6.48", 0, 1700, exp_ratio(8'h44, 0, 0));
    setup(0, 8'h45, 0, 1'b0); run_case("R4 19.44", 0, 2429, 2430);
    setup(0, 8'h45, 1, 1'b0); run_case("R4 19.44b", 0, 2440, exp_ratio(8'h45, 0, 0));
    setup(0, 8'h49, 0, 1'b0); run_case("R4 77.76", 0, 9725, exp_ratio(8'h49, 0, 0));

    // R6: shared N+1 used by two inputs
    setup(0, 8'hC5, 4, 1'b0); run_case("R6 in0", 0, 23, 5);
    setup(1, 8'hC3, 4, 1'b0); run_case("R6 in1", 1, 10, 5);

    // R7: divide bit alone is ignored
    setup(2, 8'h85, 4, 1'b0); run_case("R7", 2, 6, 1);

    // R8: flag follows any input's divide bit
    @(negedge clk); ref_cfg = '0; #1;
    check("R8 none", int'(freq_mon_off), 0);
    ref_cfg[3*CW + 7] = 1'b1; #1;
    check("R8 unselected", int'(freq_mon_off), 1);
    ref_cfg = '0; #1;
    check("R8 cleared", int'(freq_mon_off), 0);

    // R9: falling-edge selection
    setup(0, 8'h00, 0, 1'b1);
    ref_in[0] = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 rise ignored", pulse_cnt, 0);
    ref_in[0] = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R9 fall lat2", int'(cmp_pulse), 0);
    @(negedge clk);
    check("R9 fall lat3", int'(cmp_pulse), 1);
    settle();
    setup(0, 8'hC0, 2, 1'b1); run_case("R9 div3", 0, 9, 3);

    // R10: selection change restarts a partial count
    setup(0, 8'hC0, 3, 1'b0);
    toggles(0, 3);
    @(negedge clk); ref_sel = 2'd1;
    @(negedge clk); ref_sel = 2'd0;
    settle();
    run_case("R10 restart", 0, 1, 4);
    toggles(0, 3);
    repeat (6) @(negedge clk);
    check("R10 after", pulse_cnt, 1);

    // R11: unselected input ignored
    setup(0, 8'h00, 0, 1'b0);
    pulse_cnt = 0;
    toggles(3, 10);
    repeat (6) @(negedge clk);
    check("R11", pulse_cnt, 0);

    // Random mix of modes (R4 R6 R9 R5)
    for (int it = 0; it < 12; it++) begin
      int idx, code, n, r, edges;
      bit [7:0] w;
      bit fall;
      idx = int'($urandom_range(0, 3));
      code = int'($urandom_range(0, 15));
      if (code >= 4 && code <= 9) code = 3;
      n = int'($urandom_range(1, 63));
      fall = 1'($urandom_range(0, 1));
      w = {1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 6'(code)};
      if (1'($urandom_range(0, 1)) != sonet_m) begin
        sonet_m = ~sonet_m;
        set_net(sonet_m);
      end
      setup(idx, w, n, fall);
      r = exp_ratio(w, n, sonet_m);
      edges = int'($urandom_range(0, 2 * r + 2));
      run_case("R4 R6 rand", idx, edges, r);
    end

    check("R2 width", width_err, 0);
    summary();
  end
endmodule